// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block is the register front end of a 32-input interrupt controller. A word-addressed bus port reaches one configuration word per interrupt input, an enable word, two write-only aliases that set or clear chosen enable bits without a read-modify-write, and a read-only pending word. The block does not interpret the contents of the configuration words; it only stores them for the arbitration logic further on.

The pending vector is formed every cycle from the enable word and the request sources. Each external request line passes through a two-flop synchronizer. Each software request bit arrives on an input vector from elsewhere in the controller. A pending bit is high exactly while its enable bit is set and one of its two sources is active. The vector goes straight to the downstream priority logic and can also be read over the bus.

A parameter states how many inputs are actually present. Configuration words, enable bits and pending bits of missing inputs are hard zero and cannot be written.

Top module: `irq_csr_bank`

## Requirements
- R1: After reset all configuration words, the enable word, the pending vector and the read data are zero.
- R2: A configuration word at word offset n (0 ≤ n < NUM_IRQ) stores all bits written to it, and a read returns that value.
- R3: Offset 32 is the enable word. A write replaces it, a read returns it, and bit n enables input n.
- R4: A write to offset 33 sets each enable bit whose data bit is 1 and leaves the others as they were. A read of offset 33 returns 0.
- R5: A write to offset 34 clears each enable bit whose data bit is 1 and leaves the others as they were. A read of offset 34 returns 0.
- R6: Pending bit n equals enable[n] AND (synchronized request[n] OR software bit[n]). It is driven on `pendingOut` and read at offset 35. Writes to offset 35 have no effect.
- R7: A software request bit reaches `pendingOut` in the same cycle. An external request reaches it after the second rising clock edge that samples it.
- R8: An input whose enable bit is clear never shows as pending, however its sources are driven.
- R9: For an index at or above NUM_IRQ, the configuration word reads 0, the enable bit reads 0 and the pending bit is 0, and writes do not change them.
- R10: Offsets 36 to 63 read as 0, and writes to them change no register.
- R11: Read data appears on `busRdData` after the clock edge that samples `busRdEn` high, and holds its value while `busRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Word offset of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqReq | input | 32 | Asynchronous external request levels |
| swIrq | input | 32 | Software request levels from the controller |
| pendingOut | output | 32 | Enabled, active requests for priority logic |

## Verification
The sharpest coincidence is a clear-alias write landing on the same clock edge at which a newly raised external request leaves the synchronizer. A correct bank never lets that input's pending bit go high. The bench raises the request one cycle before the clear write, so the second synchronizer flop and the enable register update on the same edge. It then samples `pendingOut` after that edge and again a cycle later, and requires the bit to stay low both times. A second case puts a set-alias write on an input whose request is already held, and requires the pending bit right after that edge.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int MAX_IRQ  = 32;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int IDX_W    = $clog2(MAX_IRQ);
  localparam int OFS_EN   = 32;
  localparam int OFS_SET  = 33;
  localparam int OFS_CLR  = 34;
  localparam int OFS_PEND = 35;

  typedef enum logic [1:0] {
    RD_CFG  = 2'd0,
    RD_EN   = 2'd1,
    RD_PEND = 2'd2,
    RD_ZERO = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic             cfgWr;
    logic [IDX_W-1:0] cfgIdx;
    logic             enWr;
    logic             enSet;
    logic             enClr;
    logic             rdStb;
    rdSel_e           rdSel;
  } csrStrobe_t;
endpackage

// File: rtl/irq_csr_ctrl.sv
module irq_csr_ctrl
  import irq_csr_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output csrStrobe_t        stb
);
  logic isCfg;
  logic isEn;
  logic isSet;
  logic isClr;
  logic isPend;

  always_comb begin
    isCfg  = (busAddr < ADDR_W'(OFS_EN));
    isEn   = (busAddr == ADDR_W'(OFS_EN));
    isSet  = (busAddr == ADDR_W'(OFS_SET));
    isClr  = (busAddr == ADDR_W'(OFS_CLR));
    isPend = (busAddr == ADDR_W'(OFS_PEND));

    stb        = '0;
    stb.cfgIdx = busAddr[IDX_W-1:0];
    stb.cfgWr  = busWrEn && isCfg;
    stb.enWr   = busWrEn && isEn;
    stb.enSet  = busWrEn && isSet;
    stb.enClr  = busWrEn && isClr;
    stb.rdStb  = busRdEn;
    if (isCfg)       stb.rdSel = RD_CFG;
    else if (isEn)   stb.rdSel = RD_EN;
    else if (isPend) stb.rdSel = RD_PEND;
    else             stb.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/irq_csr_dp.sv
module irq_csr_dp
  import irq_csr_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int CFG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  csrStrobe_t         stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [MAX_IRQ-1:0] irqReq,
  input  logic [MAX_IRQ-1:0] swIrq,
  output logic [DATA_W-1:0]  rdData,
  output logic [MAX_IRQ-1:0] pending
);
  localparam logic [MAX_IRQ:0]   ONE_EXT    = 1;
  localparam logic [MAX_IRQ-1:0] VALID_MASK = MAX_IRQ'((ONE_EXT << NUM_IRQ) - 1);

  logic [CFG_W-1:0]   cfgReg [MAX_IRQ];
  logic [MAX_IRQ-1:0] enReg;
  logic [MAX_IRQ-1:0] syncQ [SYNC_STAGES];
  logic [MAX_IRQ-1:0] reqSync;

  // Per-input configuration words; absent inputs are tied to zero.
  for (genvar g = 0; g < MAX_IRQ; g++) begin : gCfg
    if (g < NUM_IRQ) begin : gLive
      logic [CFG_W-1:0] cfgQ;
      always_ff @(posedge clk) begin
        if (!rstN)
          cfgQ <= '0;
        else if (stb.cfgWr && (stb.cfgIdx == IDX_W'(g)))
          cfgQ <= wrData[CFG_W-1:0];
      end
      assign cfgReg[g] = cfgQ;
    end else begin : gDead
      assign cfgReg[g] = '0;
    end
  end

  // Enable word with direct, set-alias and clear-alias writes.
  always_ff @(posedge clk) begin
    if (!rstN)
      enReg <= '0;
    else if (stb.enWr)
      enReg <= wrData[MAX_IRQ-1:0] & VALID_MASK;
    else if (stb.enSet)
      enReg <= (enReg | wrData[MAX_IRQ-1:0]) & VALID_MASK;
    else if (stb.enClr)
      enReg <= enReg & ~wrData[MAX_IRQ-1:0];
  end

  // Request synchronizer chain.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= irqReq & VALID_MASK;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign reqSync = syncQ[SYNC_STAGES-1];

  assign pending = enReg & (reqSync | swIrq) & VALID_MASK;

  // Registered read port.
  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (stb.rdStb) begin
      unique case (stb.rdSel)
        RD_CFG:  rdData <= DATA_W'(cfgReg[stb.cfgIdx]);
        RD_EN:   rdData <= DATA_W'(enReg);
        RD_PEND: rdData <= DATA_W'(pending);
        default: rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
  import irq_csr_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int CFG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [31:0] irqReq,
  input  logic [31:0] swIrq,
  output logic [31:0] pendingOut
);
  csrStrobe_t stb;

  irq_csr_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .stb     (stb)
  );

  irq_csr_dp #(
    .NUM_IRQ     (NUM_IRQ),
    .CFG_W       (CFG_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (busWrData),
    .irqReq  (irqReq),
    .swIrq   (swIrq),
    .rdData  (busRdData),
    .pending (pendingOut)
  );
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk #(
  parameter int NUM_IRQ = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  busAddr,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData,
  input logic [31:0] irqReq,
  input logic [31:0] swIrq,
  input logic [31:0] pendingOut
);
  localparam logic [32:0] ONE_EXT = 1;
  localparam logic [31:0] LIVE    = 32'((ONE_EXT << NUM_IRQ) - 1);

  // R6: a pending bit needs a software bit now or a request two edges back
  p_src_needed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendingOut & ~(swIrq | $past(irqReq, 2))) == 32'h0);

  // R5: bits named by a clear-alias write are gone from pending after the edge
  p_clear_alias_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 6'd34) |=> ((pendingOut & $past(busWrData)) == 32'h0));

  // R4: reads of the alias offsets return zero
  p_alias_reads_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && (busAddr == 6'd33 || busAddr == 6'd34)) |=> (busRdData == 32'h0));

  // R10: unmapped offsets read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr > 6'd35) |=> (busRdData == 32'h0));

  // R11: read data holds without a read strobe
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));

  // R9: absent inputs never pend
  p_absent_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendingOut & ~LIVE) == 32'h0);
endmodule

bind irq_csr_bank irq_csr_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busWrData  (busWrData),
  .busRdData  (busRdData),
  .irqReq     (irqReq),
  .swIrq      (swIrq),
  .pendingOut (pendingOut)
);

// File: tb/tb_irq_csr_bank.sv
module tb_irq_csr_bank;
  localparam int NIRQ = 20;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  busAddr;
  logic        busWrEn;
  logic        busRdEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [31:0] irqReq;
  logic [31:0] swIrq;
  logic [31:0] pendingOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_csr_bank #(.NUM_IRQ(NIRQ)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq), .swIrq(swIrq), .pendingOut(pendingOut)
  );

  typedef struct packed {
    logic        isRd;
    logic [3:0]  req;
    logic [5:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd2,  6'd3,  32'hA5A5_0003},   // R2 write cfg3
    '{1'b1, 4'd2,  6'd3,  32'hA5A5_0003},   // R2 read back
    '{1'b0, 4'd2,  6'd19, 32'h1234_5678},   // R2 last live word
    '{1'b1, 4'd2,  6'd19, 32'h1234_5678},
    '{1'b0, 4'd9,  6'd25, 32'h0000_FFFF},   // R9 absent word
    '{1'b1, 4'd9,  6'd25, 32'h0000_0000},
    '{1'b0, 4'd3,  6'd32, 32'h0000_00F0},   // R3 direct enable
    '{1'b1, 4'd3,  6'd32, 32'h0000_00F0},
    '{1'b0, 4'd4,  6'd33, 32'h0000_0005},   // R4 set alias
    '{1'b1, 4'd4,  6'd32, 32'h0000_00F5},
    '{1'b1, 4'd4,  6'd33, 32'h0000_0000},
    '{1'b0, 4'd5,  6'd34, 32'h0000_0030},   // R5 clear alias
    '{1'b1, 4'd5,  6'd32, 32'h0000_00C5},
    '{1'b1, 4'd5,  6'd34, 32'h0000_0000},
    '{1'b0, 4'd9,  6'd32, 32'hFFFF_FFFF},   // R9 enable above NUM_IRQ
    '{1'b1, 4'd9,  6'd32, 32'h000F_FFFF},
    '{1'b0, 4'd10, 6'd40, 32'h0000_DEAD},   // R10 unmapped write
    '{1'b1, 4'd10, 6'd40, 32'h0000_0000},
    '{1'b1, 4'd10, 6'd32, 32'h000F_FFFF},
    '{1'b0, 4'd6,  6'd35, 32'hFFFF_FFFF},   // R6 pending is read-only
    '{1'b1, 4'd6,  6'd35, 32'h0000_0000},
    '{1'b1, 4'd2,  6'd3,  32'hA5A5_0003}    // R2 word survives other traffic
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; busRdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busRdEn = 1'b0;
    check(tag, busRdData, exp);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rstN = 1'b0; busAddr = '0; busWrEn = 1'b0; busRdEn = 1'b0;
    busWrData = '0; irqReq = '0; swIrq = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdData", busRdData, 32'h0);
    check("R1 pending", pendingOut, 32'h0);
    busRead(6'd0, 32'h0, "R1 cfg0");
    busRead(6'd32, 32'h0, "R1 enable");
    busRead(6'd35, 32'h0, "R1 pending read");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd)
        busRead(VECS[i].addr, VECS[i].data, $sformatf("R%0d vec%0d", VECS[i].req, i));
      else
        busWrite(VECS[i].addr, VECS[i].data);
    end

    // R7 software bits are combinational; enable is 000FFFFF here
    swIrq = 32'h0000_0101;
    #1;
    check("R7 sw same cycle", pendingOut, 32'h0000_0101);
    busRead(6'd35, 32'h0000_0101, "R6 pending read");

    // R8 disabled input stays out
    busWrite(6'd34, 32'h0000_0100);
    check("R8 disabled sw", pendingOut, 32'h0000_0001);
    swIrq = 32'h0;

    // R7 external request through two flops
    irqReq = 32'h0000_0004;
    @(posedge clk); @(negedge clk);
    check("R7 after one edge", pendingOut, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R7 after two edges", pendingOut, 32'h0000_0004);
    irqReq = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 follows level", pendingOut, 32'h0);

    // R9 sources on absent inputs
    swIrq = 32'hFFF0_0000; irqReq = 32'hFFF0_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 absent pend", pendingOut, 32'h0);
    swIrq = 32'h0; irqReq = 32'h0;

    // R5 clear write on the edge the request leaves the synchronizer
    repeat (2) @(negedge clk);
    irqReq = 32'h0000_0020;
    @(posedge clk); @(negedge clk);
    busWrite(6'd34, 32'h0000_0020);
    check("R5 clear vs arrival", pendingOut & 32'h20, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 held request masked", pendingOut & 32'h20, 32'h0);

    // R4 set write while request held
    busWrite(6'd33, 32'h0000_0020);
    check("R4 set with held request", pendingOut, 32'h0000_0020);
    irqReq = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 drop after release", pendingOut, 32'h0);

    // R11 read data holds without strobe
    busRead(6'd19, 32'h1234_5678, "R11 read");
    held = busRdData;
    busAddr = 6'd3;
    repeat (2) @(negedge clk);
    check("R11 hold", busRdData, held);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule